// File: doc/BRIEF.md
# Store-Conditional Reservation Unit

This unit decides whether a byte-wide conditional store may reach memory, and it reports the result as a 4-bit condition field. It keeps one reservation, made of a valid flag, a reserved address and a reserved access size. A load-reserve port installs the reservation. An external kill input can drop it at any time, for example when another agent writes to the reserved location.

When a conditional-store instruction word is presented, the unit decodes the register specifiers and puts them on select outputs. It then takes the base, index and source values that come back in the same cycle. It forms the effective address and compares that address with the reservation. One cycle later it presents a done pulse, the condition field and, when the store succeeds, a one-byte write strobe with its address and data. Every recognised conditional store consumes the reservation, whether or not it succeeds. Address translation is an identity mapping.

A parameter sets the policy for a reservation that is close but not exact, meaning it sits in the same smallest page but not at the same address and size. Such a request either fails without writing, or writes and reports success.

Top module: `sc_resv_unit`

## Requirements
- R1: A request is recognised only when `req_insn[31:26]`=31, `req_insn[10:1]`=694 and `req_insn[0]`=1. Any other word gives no done pulse and no write, and leaves the reservation untouched. `src_sel`=`req_insn[25:21]`, `base_sel`=`req_insn[20:16]` and `index_sel`=`req_insn[15:11]` at all times.
- R2: The effective address is `index_val` plus `base_val`, modulo 2^XLEN. When `base_sel` is 0, the base contributes zero whatever `base_val` holds.
- R3: When the reservation is valid, its size is 1 and its address equals the effective address, the unit writes. `mem_we` pulses with `mem_addr` set to the effective address and `mem_data` set to `src_byte`.
- R4: With no valid reservation, there is no write and the success bit is 0.
- R5: The request fails without writing, with a success bit of 0, when the reservation is valid and not exact, and the effective address differs from the reserved address in some bit at or above log2(PAGE_BYTES).
- R6: A request is in the same-page inexact case when the reservation is valid, it is not exact (the address or the size differs), and bits XLEN-1 down to log2(PAGE_BYTES) of both addresses agree. With NEAR_STORE=0 this case fails without a write. With NEAR_STORE=1 it writes and reports success.
- R7: `cr_out`={2'b00, success, so_in}, where `cr_out[1]` is the success bit and `cr_out[0]` is `so_in` sampled with the request. The success bit equals whether a write was issued.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. Results appear on the next cycle with `done` high for exactly one cycle. `req_ready` is low while `done` is high, and a request offered then is ignored.
- R9: Every accepted conditional store clears the reservation, whether it succeeds or fails.
- R10: `lr_valid` installs the valid flag, `lr_addr` and `lr_size`, and replaces any older reservation. `rsv_kill` drops the reservation. When a load-reserve arrives in the same cycle as a kill or an accepted store, the new reservation survives. A store accepted in that cycle is judged against the old reservation.
- R11: After reset there is no reservation, `done` and `mem_we` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_valid | input | 1 | Load-reserve: install a reservation |
| lr_addr | input | XLEN | Reserved real address |
| lr_size | input | SZW | Reserved access size in bytes |
| rsv_kill | input | 1 | Drop the reservation |
| req_valid | input | 1 | Instruction word offered |
| req_insn | input | 32 | Instruction word |
| req_ready | output | 1 | No operation in flight |
| src_sel | output | 5 | Source register specifier |
| base_sel | output | 5 | Base register specifier |
| index_sel | output | 5 | Index register specifier |
| src_byte | input | 8 | Least significant byte of the source register |
| base_val | input | XLEN | Base register value |
| index_val | input | XLEN | Index register value |
| so_in | input | 1 | Current summary-overflow bit |
| done | output | 1 | One-cycle completion pulse |
| cr_out | output | 4 | Condition result |
| mem_we | output | 1 | One-byte write strobe |
| mem_addr | output | XLEN | Write address |
| mem_data | output | 8 | Write data |

## Verification
A stale or wrongly loaded reservation shows up at the ports on the very next conditional store. The cycle after acceptance carries a `mem_we` and success bit that disagree with the reservation the bench installed. A reservation that is not cleared reveals itself one request later, as a second store to the same address succeeding. A wrong page boundary or near-match policy appears only on addresses that straddle or share a page with the reservation. The bench therefore places effective addresses on both sides of a page edge. It also runs a second instance with the other policy, so that both outcomes of the same-page case are compared.

// File: rtl/sc_resv_pkg.sv
package sc_resv_pkg;
  localparam int unsigned INSN_W = 32;
  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXT_OP     = 10'd694;

  typedef struct packed {
    logic [4:0] src;
    logic [4:0] base;
    logic [4:0] index;
  } sc_fields_t;

  // Result of comparing a request with the reservation.
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,  // no valid reservation
    OUT_HIT  = 2'd1,  // exact address and size
    OUT_NEAR = 2'd2,  // inexact, same smallest page
    OUT_FAR  = 2'd3   // inexact, different page
  } sc_outcome_e;

  function automatic logic sc_is_cond_store(input logic [INSN_W-1:0] w);
    return (w[31:26] == PRIMARY_OP) && (w[10:1] == EXT_OP) && w[0];
  endfunction

  function automatic sc_fields_t sc_split(input logic [INSN_W-1:0] w);
    sc_fields_t f;
    f.src   = w[25:21];
    f.base  = w[20:16];
    f.index = w[15:11];
    return f;
  endfunction
endpackage

// File: rtl/sc_resv_decode.sv
module sc_resv_decode
  import sc_resv_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              is_sc,
  output sc_fields_t        fields
);
  always_comb begin
    is_sc  = sc_is_cond_store(insn);
    fields = sc_split(insn);
  end
endmodule

// File: rtl/sc_resv_reg.sv
module sc_resv_reg #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SZW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [XLEN-1:0] set_addr,
  input  logic [SZW-1:0]  set_size,
  input  logic            kill,
  input  logic            consume,
  output logic            valid,
  output logic [XLEN-1:0] addr,
  output logic [SZW-1:0]  size
);
  // A new reservation beats any clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      size  <= '0;
    end else if (set) begin
      valid <= 1'b1;
      addr  <= set_addr;
      size  <= set_size;
    end else if (kill || consume) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_resv_judge.sv
module sc_resv_judge
  import sc_resv_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned SZW        = 4,
  parameter int unsigned PG_SHIFT   = 12,
  parameter bit          NEAR_STORE = 1'b0
) (
  input  logic            rsv_valid,
  input  logic [XLEN-1:0] rsv_addr,
  input  logic [SZW-1:0]  rsv_size,
  input  logic [XLEN-1:0] ea,
  output sc_outcome_e     outcome,
  output logic            do_store
);
  function automatic logic same_page(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a[XLEN-1:PG_SHIFT] == b[XLEN-1:PG_SHIFT];
  endfunction

  function automatic logic exact_hit(input logic [XLEN-1:0] a, input logic [SZW-1:0] s,
                                     input logic [XLEN-1:0] e);
    return (s == SZW'(1)) && (a == e);
  endfunction

  logic near_ok;

  generate
    if (NEAR_STORE) begin : g_near_store
      assign near_ok = 1'b1;
    end else begin : g_near_fail
      assign near_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!rsv_valid)                           outcome = OUT_NONE;
    else if (exact_hit(rsv_addr, rsv_size, ea)) outcome = OUT_HIT;
    else if (same_page(rsv_addr, ea))          outcome = OUT_NEAR;
    else                                       outcome = OUT_FAR;
    do_store = (outcome == OUT_HIT) || ((outcome == OUT_NEAR) && near_ok);
  end
endmodule

// File: rtl/sc_resv_unit.sv
module sc_resv_unit
  import sc_resv_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned SZW        = 4,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter bit          NEAR_STORE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_valid,
  input  logic [XLEN-1:0]   lr_addr,
  input  logic [SZW-1:0]    lr_size,
  input  logic              rsv_kill,
  input  logic              req_valid,
  input  logic [INSN_W-1:0] req_insn,
  output logic              req_ready,
  output logic [4:0]        src_sel,
  output logic [4:0]        base_sel,
  output logic [4:0]        index_sel,
  input  logic [7:0]        src_byte,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic              so_in,
  output logic              done,
  output logic [3:0]        cr_out,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [7:0]        mem_data
);
  localparam int unsigned PG_SHIFT = $clog2(PAGE_BYTES);

  function automatic logic [XLEN-1:0] eff_addr(input logic [4:0] bsel,
                                               input logic [XLEN-1:0] b,
                                               input logic [XLEN-1:0] x);
    return x + ((bsel == 5'd0) ? '0 : b);
  endfunction

  logic              is_sc;
  sc_fields_t        fields;
  logic              accept;
  logic [XLEN-1:0]   ea;
  logic              rsv_valid;
  logic [XLEN-1:0]   rsv_addr;
  logic [SZW-1:0]    rsv_size;
  sc_outcome_e       outcome;
  logic              do_store;
  logic              done_q, we_q;
  logic [3:0]        cr_q;
  logic [XLEN-1:0]   addr_q;
  logic [7:0]        data_q;

  sc_resv_decode u_dec (
    .insn   (req_insn),
    .is_sc  (is_sc),
    .fields (fields)
  );

  assign src_sel   = fields.src;
  assign base_sel  = fields.base;
  assign index_sel = fields.index;
  assign req_ready = !done_q;
  assign accept    = req_valid && req_ready && is_sc;
  assign ea        = eff_addr(fields.base, base_val, index_val);

  sc_resv_reg #(.XLEN(XLEN), .SZW(SZW)) u_rsv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (lr_valid),
    .set_addr (lr_addr),
    .set_size (lr_size),
    .kill     (rsv_kill),
    .consume  (accept),
    .valid    (rsv_valid),
    .addr     (rsv_addr),
    .size     (rsv_size)
  );

  sc_resv_judge #(
    .XLEN(XLEN), .SZW(SZW), .PG_SHIFT(PG_SHIFT), .NEAR_STORE(NEAR_STORE)
  ) u_judge (
    .rsv_valid (rsv_valid),
    .rsv_addr  (rsv_addr),
    .rsv_size  (rsv_size),
    .ea        (ea),
    .outcome   (outcome),
    .do_store  (do_store)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      cr_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= accept;
      we_q   <= accept && do_store;
      if (accept) begin
        cr_q   <= {2'b00, do_store, so_in};
        addr_q <= ea;
        data_q <= src_byte;
      end
    end
  end

  assign done     = done_q;
  assign mem_we   = we_q;
  assign cr_out   = cr_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
endmodule

// File: rtl/sc_resv_unit_chk.sv
module sc_resv_unit_chk
  import sc_resv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        lr_valid,
  input logic        rsv_valid,
  input sc_outcome_e outcome,
  input logic        done,
  input logic        mem_we,
  input logic [3:0]  cr_out,
  input logic        req_ready,
  input logic        so_in
);
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> done); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !req_ready); // R8
  AST_WE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> done); // R3
  AST_HIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n) (accept && outcome == OUT_HIT) |=> mem_we); // R3
  AST_NO_RSV_NO_WE: assert property (@(posedge clk) disable iff (!rst_n) (accept && !rsv_valid) |=> !mem_we); // R4
  AST_FAR_NO_WE: assert property (@(posedge clk) disable iff (!rst_n) (accept && outcome == OUT_FAR) |=> !mem_we); // R5
  AST_CR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> cr_out[3:2] == 2'b00); // R7
  AST_EQ_MATCHES_WE: assert property (@(posedge clk) disable iff (!rst_n) done |-> cr_out[1] == mem_we); // R7
  AST_SO_ECHO: assert property (@(posedge clk) disable iff (!rst_n) accept |=> cr_out[0] == $past(so_in)); // R7
  AST_RSV_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n) (accept && !lr_valid) |=> !rsv_valid); // R9
  AST_LR_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n) lr_valid |=> rsv_valid); // R10
endmodule

bind sc_resv_unit sc_resv_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .lr_valid  (lr_valid),
  .rsv_valid (rsv_valid),
  .outcome   (outcome),
  .done      (done),
  .mem_we    (mem_we),
  .cr_out    (cr_out),
  .req_ready (req_ready),
  .so_in     (so_in)
);

// File: tb/sc_resv_unit_test.sv
module sc_resv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RA_ADDR = 64'h0000_0000_1000_2345;

  typedef struct packed {
    logic        do_set;
    logic [63:0] set_addr;
    logic [3:0]  set_size;
    logic [4:0]  ra;
    logic [63:0] base;
    logic [63:0] idx;
    logic [7:0]  src;
    logic        so;
    logic        we_dflt;
    logic        we_alt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, RA_ADDR, 4'd1, 5'd3, 64'h1000_2000, 64'h345, 8'h88, 1'b0, 1'b1, 1'b1},  // R3 exact hit
    '{1'b0, RA_ADDR, 4'd1, 5'd3, 64'h1000_2000, 64'h345, 8'h77, 1'b1, 1'b0, 1'b0},  // R4 R9 consumed
    '{1'b1, RA_ADDR, 4'd1, 5'd0, 64'hDEAD_BEEF, RA_ADDR, 8'h99, 1'b1, 1'b1, 1'b1},  // R2 base spec 0
    '{1'b1, RA_ADDR, 4'd1, 5'd7, RA_ADDR, 64'h1, 8'h11, 1'b0, 1'b0, 1'b1},          // R6 addr+1
    '{1'b1, RA_ADDR, 4'd4, 5'd2, RA_ADDR, 64'h0, 8'h22, 1'b1, 1'b0, 1'b1},          // R6 size mismatch
    '{1'b1, RA_ADDR, 4'd1, 5'd4, RA_ADDR, 64'h1000, 8'h33, 1'b0, 1'b0, 1'b0},       // R5 next page
    '{1'b1, RA_ADDR, 4'd1, 5'd5, '1, RA_ADDR + 64'd1, 8'h44, 1'b1, 1'b1, 1'b1},     // R2 wrap
    '{1'b1, 64'hFFF, 4'd1, 5'd6, 64'h1000, 64'h0, 8'h55, 1'b0, 1'b0, 1'b0},         // R5 page edge
    '{1'b1, RA_ADDR, 4'd1, 5'd1, RA_ADDR, 64'hFFF, 8'h66, 1'b0, 1'b0, 1'b0},        // R5 far above
    '{1'b1, RA_ADDR, 4'd1, 5'd1, 64'h1000_2000, 64'h344, 8'hAA, 1'b1, 1'b0, 1'b1}   // R6 addr-1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lr_valid = 1'b0, rsv_kill = 1'b0, req_valid = 1'b0, so_in = 1'b0;
  logic [63:0] lr_addr = '0, base_val = '0, index_val = '0;
  logic [3:0] lr_size = '0;
  logic [31:0] req_insn = '0;
  logic [7:0] src_byte = '0;

  logic rdy_d, done_d, we_d, rdy_a, done_a, we_a;
  logic [4:0] ss_d, bs_d, is_d, ss_a, bs_a, is_a;
  logic [3:0] cr_d, cr_a;
  logic [63:0] ad_d, ad_a;
  logic [7:0] md_d, md_a;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_resv_unit uut (
    .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_size(lr_size),
    .rsv_kill(rsv_kill), .req_valid(req_valid), .req_insn(req_insn), .req_ready(rdy_d),
    .src_sel(ss_d), .base_sel(bs_d), .index_sel(is_d), .src_byte(src_byte),
    .base_val(base_val), .index_val(index_val), .so_in(so_in), .done(done_d),
    .cr_out(cr_d), .mem_we(we_d), .mem_addr(ad_d), .mem_data(md_d));

  sc_resv_unit #(.NEAR_STORE(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_size(lr_size),
    .rsv_kill(rsv_kill), .req_valid(req_valid), .req_insn(req_insn), .req_ready(rdy_a),
    .src_sel(ss_a), .base_sel(bs_a), .index_sel(is_a), .src_byte(src_byte),
    .base_val(base_val), .index_val(index_val), .so_in(so_in), .done(done_a),
    .cr_out(cr_a), .mem_we(we_a), .mem_addr(ad_a), .mem_data(md_a));

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] ra, input logic [4:0] rb);
    return {6'd31, rs, ra, rb, 10'd694, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lr(input logic [63:0] a, input logic [3:0] s);
    @(negedge clk);
    lr_valid = 1'b1; lr_addr = a; lr_size = s;
    @(negedge clk);
    lr_valid = 1'b0;
  endtask

  // Offer one request; returns at the negedge where results are visible.
  task automatic sc(input logic [31:0] w, input logic [63:0] b, input logic [63:0] x,
                    input logic [7:0] s, input logic so);
    @(negedge clk);
    req_valid = 1'b1; req_insn = w; base_val = b; index_val = x; src_byte = s; so_in = so;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", {63'd0, done_d}, 64'd0);
    check("R11 mem_we", {63'd0, we_d}, 64'd0);
    check("R11 ready", {63'd0, rdy_d}, 64'd1);
    rst_n = 1'b1;
    // R11 no reservation after reset: exact address still fails
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, RA_ADDR, 8'h5A, 1'b0);
    check("R11 R4 no-rsv done", {63'd0, done_d}, 64'd1);
    check("R11 R4 no-rsv we", {63'd0, we_d}, 64'd0);

    // R1 field selects
    req_insn = mk(5'd9, 5'd3, 5'd17);
    #1;
    check("R1 src_sel", {59'd0, ss_d}, 64'd9);
    check("R1 base_sel", {59'd0, bs_d}, 64'd3);
    check("R1 index_sel", {59'd0, is_d}, 64'd17);

    // Vector table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [63:0] ea;
      ea = VECS[i].idx + ((VECS[i].ra == 5'd0) ? 64'd0 : VECS[i].base);
      if (VECS[i].do_set) lr(VECS[i].set_addr, VECS[i].set_size);
      sc(mk(5'd8, VECS[i].ra, 5'd9), VECS[i].base, VECS[i].idx, VECS[i].src, VECS[i].so);
      check($sformatf("R8 vec%0d done", i), {63'd0, done_d}, 64'd1);
      check($sformatf("R3 R6 vec%0d we dflt", i), {63'd0, we_d}, {63'd0, VECS[i].we_dflt});
      check($sformatf("R6 vec%0d we alt", i), {63'd0, we_a}, {63'd0, VECS[i].we_alt});
      check($sformatf("R7 vec%0d cr dflt", i), {60'd0, cr_d}, {60'd0, 2'b00, VECS[i].we_dflt, VECS[i].so});
      check($sformatf("R7 vec%0d cr alt", i), {60'd0, cr_a}, {60'd0, 2'b00, VECS[i].we_alt, VECS[i].so});
      if (VECS[i].we_alt) begin
        check($sformatf("R2 vec%0d addr", i), ad_a, ea);
        check($sformatf("R3 vec%0d data", i), {56'd0, md_a}, {56'd0, VECS[i].src});
      end
    end

    // R1 unrecognised words leave reservation intact
    lr(RA_ADDR, 4'd1);
    sc({6'd31, 5'd1, 5'd0, 5'd2, 10'd693, 1'b1}, 64'd0, RA_ADDR, 8'h01, 1'b0);
    check("R1 bad xo no done", {63'd0, done_d}, 64'd0);
    sc({6'd31, 5'd1, 5'd0, 5'd2, 10'd694, 1'b0}, 64'd0, RA_ADDR, 8'h02, 1'b0);
    check("R1 rc0 no done", {63'd0, done_d}, 64'd0);
    check("R1 rc0 no we", {63'd0, we_d}, 64'd0);
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, RA_ADDR, 8'h03, 1'b0);
    check("R1 rsv kept", {63'd0, we_d}, 64'd1);

    // R10 kill drops reservation
    lr(RA_ADDR, 4'd1);
    @(negedge clk); rsv_kill = 1'b1;
    @(negedge clk); rsv_kill = 1'b0;
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, RA_ADDR, 8'h04, 1'b0);
    check("R10 kill", {63'd0, we_d}, 64'd0);

    // R10 set beats kill in the same cycle
    @(negedge clk); lr_valid = 1'b1; lr_addr = RA_ADDR; lr_size = 4'd1; rsv_kill = 1'b1;
    @(negedge clk); lr_valid = 1'b0; rsv_kill = 1'b0;
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, RA_ADDR, 8'h05, 1'b0);
    check("R10 set wins kill", {63'd0, we_d}, 64'd1);

    // R10 newer reservation replaces older
    lr(RA_ADDR, 4'd1);
    lr(64'h0000_0000_2000_0000, 4'd1);
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, RA_ADDR, 8'h06, 1'b0);
    check("R10 override old", {63'd0, we_d}, 64'd0);

    // R10 R9 set concurrent with accepted store
    lr(RA_ADDR, 4'd1);
    @(negedge clk);
    req_valid = 1'b1; req_insn = mk(5'd1, 5'd0, 5'd2); base_val = '0; index_val = RA_ADDR;
    src_byte = 8'h07; so_in = 1'b0;
    lr_valid = 1'b1; lr_addr = 64'h0000_0000_3000_0010; lr_size = 4'd1;
    @(negedge clk);
    req_valid = 1'b0; lr_valid = 1'b0;
    check("R10 old rsv judged", {63'd0, we_d}, 64'd1);
    sc(mk(5'd1, 5'd0, 5'd2), 64'd0, 64'h0000_0000_3000_0010, 8'h08, 1'b0);
    check("R10 new rsv survives", {63'd0, we_d}, 64'd1);

    // R8 request held across busy cycle
    lr(RA_ADDR, 4'd1);
    @(negedge clk);
    req_valid = 1'b1; req_insn = mk(5'd1, 5'd0, 5'd2); index_val = RA_ADDR; so_in = 1'b1;
    @(negedge clk);
    check("R8 first done", {63'd0, done_d}, 64'd1);
    check("R8 ready low", {63'd0, rdy_d}, 64'd0);
    @(negedge clk);
    check("R8 ignored while busy", {63'd0, done_d}, 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second done", {63'd0, done_d}, 64'd1);
    check("R9 second fails", {63'd0, we_d}, 64'd0);
    @(negedge clk);
    check("R8 single pulse", {63'd0, done_d}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule